// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block holds the region lock bits and the general-purpose configuration bits of an embedded flash controller, and runs the commands that change or report them. Software talks to it through a small register port with four addresses: a mode word, a command word, a status word and a result word. A command word carries a key, an opcode and an argument. A command that passes the checks drops the ready flag, stays busy for a fixed number of cycles, applies its effect, and raises ready again.

A get-lock command takes a snapshot of every lock bit. Software then reads the snapshot out one 32-bit word at a time through the result address. The port does only one access per cycle. Read data is combinational from the state before the clock edge. Any side effect of a read (clearing the error flag, moving the result pointer) takes place at that edge. There is no data stream at the edge of the block, so the port has no valid/ready handshake and no back-pressure. A command written while the block is busy is refused and flagged instead of being queued.

Top module: `lockbit_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, the error flag is 0, and every lock bit and configuration bit is 0. A result read before any get-lock command returns 0.
- R2: A command word is key in bits [31:24], argument in bits [23:8] and opcode in bits [7:0]. If the key is not `KEY`, status bit 1 (error) is set, nothing changes, and `cmd_ready` keeps its value.
- R3: An accepted command drives `cmd_ready` low on the next cycle. It stays low for `BUSY_CYCLES` cycles, and the command's effect becomes visible in the same cycle that `cmd_ready` rises again.
- R4: `irq` is high exactly when `cmd_ready` is high and bit 0 of the mode word (interrupt enable) is 1.
- R5: The set-lock opcode (`OP_SET`) sets the lock bit whose index is the argument.
- R6: The clear-lock opcode (`OP_CLR`) clears the lock bit whose index is the argument.
- R7: A set-lock or clear-lock with an index of `NUM_REGIONS` or more changes no lock bit. A set-configuration command with an index of `NUM_GP` or more changes no configuration bit.
- R8: The get-lock opcode (`OP_GET`) ignores its argument. It snapshots the lock bits when it completes. Successive result reads then return lock bits [31:0], then [63:32], and so on. Once all ceil(`NUM_REGIONS`/32) words have been read, further reads return 0.
- R9: The set-configuration opcode (`OP_GP`) sets configuration bit n. These bits appear in status bits [16+n] and never affect the lock bits.
- R10: A status read clears the error flag. If a refused command write comes in the same cycle, the flag stays set.
- R11: A command with a correct key is also refused and flagged if its opcode is unknown or if it arrives while the block is busy. It is not run, and it does not extend the busy period.
- R12: The mode address reads back the enable bit in bit 0. The command address reads 0. Status bit 0 mirrors `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when reg_wr is high) |
| reg_addr | input | 2 | 0 mode, 1 command, 2 status, 3 result |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| cmd_ready | output | 1 | High when no command is in progress |
| irq | output | 1 | Ready interrupt, gated by the mode enable |

## Verification
A wrong lock bit stays hidden until a get-lock completes and the matching result word is read. The reference model therefore follows every edit with a full readout. A wrong busy count shows up on `cmd_ready` and `irq` in the very cycle it goes wrong, because both are compared against the model on every clock. A result pointer that advances wrongly shows as a word that is misplaced or not zero on the next result read. An error flag that is handled wrongly shows on the next status read.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_CMD  = 2'd1,
    A_STAT = 2'd2,
    A_RES  = 2'd3
  } addr_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET,
    ACT_CLR,
    ACT_GET,
    ACT_GP
  } act_e;

  typedef struct packed {
    act_e        act;
    logic [15:0] arg;
  } cmd_t;
endpackage

// File: rtl/lkc_decode.sv
module lkc_decode
  import lkc_pkg::*;
#(
  parameter logic [7:0] KEY    = 8'hA5,
  parameter logic [7:0] OP_SET = 8'h08,
  parameter logic [7:0] OP_CLR = 8'h09,
  parameter logic [7:0] OP_GET = 8'h0A,
  parameter logic [7:0] OP_GP  = 8'h0B
) (
  input  logic        wr_cmd,
  input  logic        busy,
  input  logic [31:0] wdata,
  output logic        accept,
  output logic        reject,
  output cmd_t        cmd
);
  logic key_ok;

  always_comb begin
    key_ok  = (wdata[31:24] == KEY);
    cmd.arg = wdata[23:8];
    if (wdata[7:0] == OP_SET)      cmd.act = ACT_SET;
    else if (wdata[7:0] == OP_CLR) cmd.act = ACT_CLR;
    else if (wdata[7:0] == OP_GET) cmd.act = ACT_GET;
    else if (wdata[7:0] == OP_GP)  cmd.act = ACT_GP;
    else                           cmd.act = ACT_NONE;
    reject = wr_cmd && (!key_ok || busy || cmd.act == ACT_NONE);
    accept = wr_cmd && !reject;
  end
endmodule

// File: rtl/lkc_timer.sv
module lkc_timer #(
  parameter int BUSY_CYCLES = 4,
  parameter int CW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic          busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));
  assign busy = (cnt != '0);
endmodule

// File: rtl/lkc_store.sv
module lkc_store
  import lkc_pkg::*;
#(
  parameter int NUM_REGIONS = 64,
  parameter int NUM_GP      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   apply,
  input  cmd_t                   cmd,
  output logic [NUM_REGIONS-1:0] lock_q,
  output logic [NUM_GP-1:0]      gp_q
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lock
    logic hit;
    assign hit = apply && (cmd.arg == 16'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          lock_q[g] <= 1'b0;
      else if (hit && cmd.act == ACT_SET)  lock_q[g] <= 1'b1;
      else if (hit && cmd.act == ACT_CLR)  lock_q[g] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gp_q[g] <= 1'b0;
      else if (apply && cmd.act == ACT_GP && cmd.arg == 16'(g)) gp_q[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/lkc_result.sv
module lkc_result #(
  parameter int NUM_REGIONS = 64,
  parameter int NWORDS      = 2,
  parameter int PW          = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [NUM_REGIONS-1:0] lock_bits,
  input  logic                   adv,
  output logic [31:0]            word
);
  logic [NWORDS*32-1:0] snap;
  logic [PW-1:0]        ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap <= '0;
      ptr  <= PW'(NWORDS);
    end else if (load) begin
      snap <= (NWORDS*32)'(lock_bits);
      ptr  <= '0;
    end else if (adv && ptr < PW'(NWORDS)) begin
      ptr  <= ptr + 1'b1;
    end
  end

  always_comb begin
    word = '0;
    for (int w = 0; w < NWORDS; w++)
      if (ptr == PW'(w)) word = snap[w*32 +: 32];
  end
endmodule

// File: rtl/lockbit_ctrl.sv
module lockbit_ctrl
  import lkc_pkg::*;
#(
  parameter int         NUM_REGIONS = 64,
  parameter int         NUM_GP      = 8,
  parameter int         BUSY_CYCLES = 4,
  parameter logic [7:0] KEY         = 8'hA5,
  parameter logic [7:0] OP_SET      = 8'h08,
  parameter logic [7:0] OP_CLR      = 8'h09,
  parameter logic [7:0] OP_GET      = 8'h0A,
  parameter logic [7:0] OP_GP       = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_ready,
  output logic        irq
);
  localparam int NWORDS = (NUM_REGIONS + 31) / 32;
  localparam int PW     = $clog2(NWORDS + 1);
  localparam int CW     = $clog2(BUSY_CYCLES + 1);

  logic                   wr_cmd, rd_eff, accept, reject, done, busy;
  logic [CW-1:0]          tmr_cnt;
  cmd_t                   dec_cmd, pend_q;
  logic                   ready_q, err_q, ien_q;
  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_GP-1:0]      gp_q;
  logic [31:0]            res_word, stat_word;

  assign wr_cmd = reg_wr && reg_addr == A_CMD;
  assign rd_eff = reg_rd && !reg_wr;

  lkc_decode #(.KEY(KEY), .OP_SET(OP_SET), .OP_CLR(OP_CLR), .OP_GET(OP_GET), .OP_GP(OP_GP)) u_dec (
    .wr_cmd(wr_cmd), .busy(busy), .wdata(reg_wdata),
    .accept(accept), .reject(reject), .cmd(dec_cmd)
  );

  lkc_timer #(.BUSY_CYCLES(BUSY_CYCLES), .CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .cnt(tmr_cnt), .done(done), .busy(busy)
  );

  lkc_store #(.NUM_REGIONS(NUM_REGIONS), .NUM_GP(NUM_GP)) u_store (
    .clk(clk), .rst_n(rst_n), .apply(done), .cmd(pend_q),
    .lock_q(lock_q), .gp_q(gp_q)
  );

  lkc_result #(.NUM_REGIONS(NUM_REGIONS), .NWORDS(NWORDS), .PW(PW)) u_res (
    .clk(clk), .rst_n(rst_n), .load(done && pend_q.act == ACT_GET),
    .lock_bits(lock_q), .adv(rd_eff && reg_addr == A_RES), .word(res_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '{act: ACT_NONE, arg: '0};
      ready_q <= 1'b1;
      err_q   <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      if (accept) pend_q <= dec_cmd;
      if (accept)    ready_q <= 1'b0;
      else if (done) ready_q <= 1'b1;
      if (reject)                              err_q <= 1'b1;
      else if (rd_eff && reg_addr == A_STAT)   err_q <= 1'b0;
      if (reg_wr && reg_addr == A_MODE) ien_q <= reg_wdata[0];
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[0] = ready_q;
    stat_word[1] = err_q;
    stat_word[16 +: NUM_GP] = gp_q;
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {31'b0, ien_q};
      A_STAT:  reg_rdata = stat_word;
      A_RES:   reg_rdata = res_word;
      default: reg_rdata = '0;
    endcase
  end

  assign cmd_ready = ready_q;
  assign irq       = ready_q && ien_q;
endmodule

// File: rtl/lkc_checker.sv
module lkc_checker #(
  parameter int         NUM_REGIONS = 64,
  parameter int         CW          = 3,
  parameter logic [7:0] KEY         = 8'hA5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic                   reg_rd,
  input logic [1:0]             reg_addr,
  input logic [31:0]            reg_wdata,
  input logic                   cmd_ready,
  input logic                   irq,
  input logic                   err_q,
  input logic [CW-1:0]          tmr_cnt,
  input logic [NUM_REGIONS-1:0] lock_q
);
  p_bad_key_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && reg_wdata[31:24] != KEY) |=> err_q);

  p_ready_fall_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ready) |-> $past(reg_wr && reg_addr == 2'd1));

  p_ready_rise_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> $past(tmr_cnt) == CW'(1));

  p_irq_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmd_ready);

  p_locks_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt != CW'(1)) |=> $stable(lock_q));

  p_stat_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 2'd2) |=> !err_q);

  p_busy_refuses_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && tmr_cnt != '0) |=> err_q);
endmodule

bind lockbit_ctrl lkc_checker #(.NUM_REGIONS(NUM_REGIONS), .CW(CW), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cmd_ready(cmd_ready), .irq(irq), .err_q(err_q),
  .tmr_cnt(tmr_cnt), .lock_q(lock_q)
);

// File: tb/lockbit_ctrl_bench.sv
module lockbit_ctrl_bench;
  localparam int NR = 64, NG = 8, BC = 4, NW = 2;
  localparam logic [7:0] KEY = 8'hA5, OSET = 8'h08, OCLR = 8'h09, OGET = 8'h0A, OGP = 8'h0B;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic cmd_ready, irq;

  lockbit_ctrl u_lockbit_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_ready(cmd_ready), .irq(irq)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  bit m_lock[NR], m_gp[NG], m_snap[NW*32];
  bit m_ready = 1, m_err = 0, m_ien = 0;
  int m_cnt = 0, m_ptr = NW, m_parg = 0;
  logic [7:0] m_pop = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_lock[i]) m_lock[i] = 0;
      foreach (m_gp[i]) m_gp[i] = 0;
      foreach (m_snap[i]) m_snap[i] = 0;
      m_ready = 1; m_err = 0; m_ien = 0; m_cnt = 0; m_ptr = NW;
    end else begin
      int oc;
      bit errset, loaded;
      oc = m_cnt; errset = 0; loaded = 0;
      if (oc != 0) begin
        if (oc == 1) begin
          m_ready = 1;
          if (m_pop == OSET && m_parg < NR) m_lock[m_parg] = 1;
          if (m_pop == OCLR && m_parg < NR) m_lock[m_parg] = 0;
          if (m_pop == OGP && m_parg < NG) m_gp[m_parg] = 1;
          if (m_pop == OGET) begin
            foreach (m_snap[i]) m_snap[i] = (i < NR) ? m_lock[i] : 0;
            m_ptr = 0; loaded = 1;
          end
        end
        m_cnt = oc - 1;
      end
      if (reg_rd && !reg_wr && reg_addr == 2'd3 && !loaded && m_ptr < NW) m_ptr++;
      if (reg_wr && reg_addr == 2'd0) m_ien = reg_wdata[0];
      if (reg_wr && reg_addr == 2'd1) begin
        logic [7:0] op;
        op = reg_wdata[7:0];
        if (reg_wdata[31:24] == KEY && oc == 0 &&
            (op == OSET || op == OCLR || op == OGET || op == OGP)) begin
          m_pop = op; m_parg = int'(reg_wdata[23:8]); m_cnt = BC; m_ready = 0;
        end else errset = 1;
      end
      if (errset) m_err = 1;
      else if (reg_rd && !reg_wr && reg_addr == 2'd2) m_err = 0;
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v;
    v = '0;
    case (reg_addr)
      2'd0: v[0] = m_ien;
      2'd2: begin
        v[0] = m_ready; v[1] = m_err;
        for (int i = 0; i < NG; i++) v[16+i] = m_gp[i];
      end
      2'd3: if (m_ptr < NW) for (int i = 0; i < 32; i++) v[i] = m_snap[m_ptr*32+i];
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check({31'b0, cmd_ready}, {31'b0, m_ready}, "cmd_ready");
    check({31'b0, irq}, {31'b0, m_ready & m_ien}, "irq");
    if (reg_rd && !reg_wr) check(reg_rdata, exp_rdata(), "reg_rdata");
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #2;
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] cw(input logic [7:0] k, input logic [7:0] op, input logic [15:0] arg);
    return {k, arg, op};
  endfunction

  task automatic run(input logic [7:0] op, input logic [15:0] arg);
    wreg(2'd1, cw(KEY, op, arg));
    idle(BC + 1);
  endtask

  task automatic dump();
    run(OGET, 16'h1234);
    rreg(2'd3); rreg(2'd3); rreg(2'd3); rreg(2'd3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tag = "R1"; idle(2); rreg(2'd2); rreg(2'd3); rreg(2'd3);
    tag = "R12"; wreg(2'd0, 32'h1); rreg(2'd0); rreg(2'd1); rreg(2'd2);
    tag = "R3"; wreg(2'd1, cw(KEY, OSET, 16'd3));
    for (int i = 0; i < BC + 2; i++) idle(1);
    tag = "R5"; run(OSET, 16'd40); run(OSET, 16'd63); run(OSET, 16'd31);
    tag = "R8"; dump();
    tag = "R6"; run(OCLR, 16'd40); run(OCLR, 16'd3); dump();
    tag = "R7"; run(OSET, 16'd64); run(OSET, 16'hFFFF); run(OCLR, 16'd64);
    run(OGP, 16'd8); run(OGP, 16'd300); dump(); rreg(2'd2);
    tag = "R9"; run(OGP, 16'd2); run(OGP, 16'd7); rreg(2'd2); dump();
    tag = "R2"; wreg(2'd1, cw(8'h5A, OSET, 16'd5)); rreg(2'd2);
    tag = "R10"; rreg(2'd2);
    wreg(2'd1, cw(8'h00, OSET, 16'd6));
    reg_wr = 1; reg_rd = 1; reg_addr = 2'd1; reg_wdata = cw(8'h11, OCLR, 16'd63);
    @(posedge clk); #2; reg_wr = 0; reg_rd = 0;
    rreg(2'd2); rreg(2'd2);
    tag = "R11"; wreg(2'd1, cw(KEY, OSET, 16'd10)); wreg(2'd1, cw(KEY, OSET, 16'd11));
    idle(BC + 1); rreg(2'd2);
    wreg(2'd1, cw(KEY, 8'h77, 16'd12)); rreg(2'd2); dump();
    tag = "R4"; wreg(2'd0, 32'h0); run(OCLR, 16'd10); wreg(2'd0, 32'h1); idle(2);
    tag = "R8"; run(OSET, 16'd0); run(OGET, 16'd0);
    rreg(2'd3); run(OGET, 16'd9); rreg(2'd3); rreg(2'd3); rreg(2'd3);
    idle(3);
    finish_run();
  end
endmodule